// File: doc/BRIEF.md
# Piecewise-Linear Gaussian Noise Generator

The block turns two streams of uniform random words into a stream of normally distributed noise samples, one per enabled clock cycle. Two xorshift (Tausworthe-style shift-register) sources supply uniform words `u` and `v`. The radial term sqrt(-2 ln u) and the angular term cos(2πv) are evaluated by piecewise-linear segment tables. Their product is a raw Gaussian value.

Each raw value is added to the raw value that follows it. The sum is multiplied by 1/sqrt(2) so that the output has unit variance. Overlapping the sums in this way smooths out the remaining segment errors. The block suits channel-simulation benches that need deep-tail noise at full clock rate. The caller holds `en` high to stream samples and lowers it to freeze the whole pipeline.

Top module: `gauss_pwl_noise`

## Requirements
- R1: While `rst` is high at a clock edge, the edge clears `noise_vld_o` and `noise_o` to 0.
- R2: After reset, `noise_vld_o` stays low for the first five enabled edges and first rises after the sixth. From then on it is high after every enabled edge and low after every edge where `en` is low.
- R3: An edge with `en` low changes no state. `noise_o` keeps its value, and the sample sequence resumes unchanged once `en` returns.
- R4: The radial source resets to 32'h2545F491 and the angular source to 32'h9E3779B9. On each enabled edge, each source advances by s^=s<<13, s^=s>>17, s^=s<<5. Sample n uses the n-th state of each source, counting the seed as state 0. The output sequence after every reset is therefore the same.
- R5: The radial term approximates sqrt(-2 ln(u/2^32)), with a zero word treated as 0.5, using 59 linear segments. Segments are chosen by leading-zero count plus one mantissa bit. All leading-zero counts of 29 and above share one segment. The term stays within [0, 6.8], so the output magnitude never exceeds 9.6.
- R6: The angular term approximates cos(2πv/2^32) using 21 uniform segments over one quarter wave. v[31:30] selects the quadrant, which is folded back onto that quarter wave. The term stays within [-1, 1], and positive and negative outputs are equally likely.
- R7: `noise_o` is signed two's complement with 24 fraction bits. Output j equals (x_j + x_(j+1)) / sqrt(2), where x_n is the raw product of the two terms for sample n.
- R8: Every output lies within 0.25 of the exact value that the R4, R5, R6 and R7 formulas give.
- R9: Over 120000 consecutive outputs, the mean lies within ±0.03 and the variance lies in [0.93, 1.07].
- R10: Over 120000 outputs, at least one output has magnitude above 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance sources and pipeline this edge |
| noise_o | output | 32 | Signed noise sample, 24 fraction bits |
| noise_vld_o | output | 1 | A new sample was produced on the last edge |

## Verification
A wrong seed, shift amount or segment coefficient moves the very first valid sample away from the floating-point reference. That sample appears six enabled edges after reset, and the 0.25 tolerance catches it there or within a few dozen samples. A broken quadrant fold or sign shows up as a lopsided sign count, and a lost tail segment shows up as a missing count beyond 4. A scaling slip shows up in the variance over the long run. A pipeline stage that ignores `en` puts the stream out of step with the reference on the first sample after a stall.

// File: rtl/gpn_pkg.sv
package gpn_pkg;

    localparam int FX_W  = 32;
    localparam int FX_FB = 24;

    typedef logic signed [FX_W-1:0] fx_t;

    typedef struct packed {
        fx_t off;
        fx_t slope;
    } seg_t;

    // natural log for x > 0, computed by range reduction and atanh series
    function automatic real r_ln(input real xin);
        real x, z, zp, s;
        int  e;
        x = xin;
        e = 0;
        while (x < 1.0) begin x = x * 2.0; e = e + 1; end
        while (x >= 2.0) begin x = x / 2.0; e = e - 1; end
        z  = (x - 1.0) / (x + 1.0);
        zp = z;
        s  = 0.0;
        for (int n = 0; n < 40; n++) begin
            s  = s + zp / real'(2 * n + 1);
            zp = zp * z * z;
        end
        return 2.0 * s - real'(e) * 0.6931471805599453;
    endfunction

    function automatic real r_sqrt(input real x);
        real y;
        if (x <= 0.0) return 0.0;
        y = (x > 1.0) ? x : 1.0;
        for (int n = 0; n < 60; n++) y = 0.5 * (y + x / y);
        return y;
    endfunction

    function automatic real r_cos(input real x);
        real t, s;
        t = 1.0;
        s = 1.0;
        for (int n = 1; n < 20; n++) begin
            t = -t * x * x / real'((2 * n - 1) * (2 * n));
            s = s + t;
        end
        return s;
    endfunction

    function automatic real r_pow2n(input int k);
        real p;
        p = 1.0;
        for (int n = 0; n < k; n++) p = p / 2.0;
        return p;
    endfunction

    function automatic fx_t to_fx(input real r);
        return fx_t'(longint'(r * 16777216.0));
    endfunction

    // radial segment i for a uw-bit uniform word
    function automatic seg_t f_seg(input int i, input int uw);
        real  lo, hi, base;
        int   nlz;
        fx_t  a, b;
        seg_t s;
        nlz = uw - 3;
        if (i < 2 * nlz) begin
            base = r_pow2n(i / 2 + 1);
            lo   = base * (1.0 + 0.5 * real'(i % 2));
            hi   = base * (1.0 + 0.5 * real'(i % 2 + 1));
        end else begin
            lo = 0.5 * r_pow2n(uw);
            hi = r_pow2n(nlz);
        end
        a = to_fx(r_sqrt(-2.0 * r_ln(lo)));
        b = to_fx(r_sqrt(-2.0 * r_ln(hi)));
        s.off   = a;
        s.slope = b - a;
        return s;
    endfunction

    // quarter-wave cosine segment i of n
    function automatic seg_t g_seg(input int i, input int n);
        fx_t  a, b;
        seg_t s;
        a = to_fx(r_cos(1.5707963267948966 * real'(i) / real'(n)));
        b = to_fx(r_cos(1.5707963267948966 * real'(i + 1) / real'(n)));
        s.off   = a;
        s.slope = b - a;
        return s;
    endfunction

endpackage

// File: rtl/gpn_urng.sv
module gpn_urng #(
    parameter logic [31:0] SEED = 32'h1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        en,
    output logic [31:0] rnd_o
);
    logic [31:0] s1, s2, s3;

    always_comb begin
        s1 = rnd_o ^ (rnd_o << 13);
        s2 = s1 ^ (s1 >> 17);
        s3 = s2 ^ (s2 << 5);
    end

    always_ff @(posedge clk) begin
        if (rst)     rnd_o <= SEED;
        else if (en) rnd_o <= s3;
    end

    // R4: the xorshift state can never reach the all-zero lock-up word
    a_r4_state_nonzero: assert property (@(posedge clk) disable iff (rst) rnd_o != 32'h0);

endmodule

// File: rtl/gpn_feval.sv
module gpn_feval
    import gpn_pkg::*;
#(
    parameter int UW  = 32,
    parameter int FRB = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [UW-1:0] u_i,
    output fx_t           f_o
);
    localparam int NLZ  = UW - 3;
    localparam int NSEG = 2 * NLZ + 1;
    localparam int IW   = $clog2(NSEG);
    localparam int LW   = $clog2(UW + 1);
    localparam int TB   = UW - NLZ;
    localparam int PW   = FX_W + FRB + 1;
    localparam fx_t F_MAX = 32'sd114085069;

    seg_t rom [NSEG];
    for (genvar i = 0; i < NSEG; i++) begin : g_rom
        localparam seg_t ENTRY = f_seg(i, UW);
        assign rom[i] = ENTRY;
    end

    logic [LW-1:0]  lz;
    logic [UW-1:0]  norm;
    logic [IW-1:0]  idx_d, idx_q;
    logic [FRB-1:0] frac_d, frac_q;
    fx_t            off_q;
    logic signed [PW-1:0] prod_q;

    always_comb begin
        lz = LW'(UW);
        for (int b = 0; b < UW; b++)
            if (u_i[b]) lz = LW'(UW - 1 - b);
        norm = u_i << lz;
        if (int'(lz) >= NLZ) begin
            idx_d  = IW'(NSEG - 1);
            frac_d = FRB'(u_i[TB-1:0]) << (FRB - TB);
        end else begin
            idx_d  = IW'(2 * int'(lz)) + IW'(norm[UW-2]);
            frac_d = norm[UW-3 -: FRB];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q  <= '0;
            frac_q <= '0;
            off_q  <= '0;
            prod_q <= '0;
            f_o    <= '0;
        end else if (en) begin
            idx_q  <= idx_d;
            frac_q <= frac_d;
            off_q  <= rom[idx_q].off;
            prod_q <= PW'(rom[idx_q].slope) * PW'($signed({1'b0, frac_q}));
            f_o    <= off_q + fx_t'(prod_q >>> FRB);
        end
    end

    // R5: the radial term never leaves [0, 6.8]
    a_r5_f_range: assert property (@(posedge clk) disable iff (rst) (f_o >= 0) && (f_o <= F_MAX));

endmodule

// File: rtl/gpn_geval.sv
module gpn_geval
    import gpn_pkg::*;
#(
    parameter int GSEG = 21,
    parameter int RB   = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        en,
    input  logic [31:0] v_i,
    output fx_t         g_o
);
    localparam int IW = $clog2(GSEG + 1);
    localparam int MW = RB + IW;
    localparam int PW = FX_W + RB + 1;
    localparam fx_t ONE = fx_t'(1) <<< FX_FB;

    seg_t rom [GSEG];
    for (genvar i = 0; i < GSEG; i++) begin : g_rom
        localparam seg_t ENTRY = g_seg(i, GSEG);
        assign rom[i] = ENTRY;
    end

    logic [RB-1:0] rr;
    logic [MW-1:0] m;
    logic [IW-1:0] idx_q;
    logic [RB-1:0] frac_q;
    logic          neg_q, neg2_q;
    fx_t           off_q, sum;
    logic signed [PW-1:0] prod_q;

    always_comb begin
        rr  = v_i[30] ? ~v_i[29 -: RB] : v_i[29 -: RB];
        m   = MW'(rr) * MW'(GSEG);
        sum = off_q + fx_t'(prod_q >>> RB);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q  <= '0;
            frac_q <= '0;
            neg_q  <= 1'b0;
            neg2_q <= 1'b0;
            off_q  <= '0;
            prod_q <= '0;
            g_o    <= '0;
        end else if (en) begin
            idx_q  <= m[MW-1:RB];
            frac_q <= m[RB-1:0];
            neg_q  <= v_i[31] ^ v_i[30];
            off_q  <= rom[idx_q].off;
            prod_q <= PW'(rom[idx_q].slope) * PW'($signed({1'b0, frac_q}));
            neg2_q <= neg_q;
            g_o    <= neg2_q ? -sum : sum;
        end
    end

    // R6: the angular term stays inside [-1, 1]
    a_r6_g_range: assert property (@(posedge clk) disable iff (rst) (g_o <= ONE) && (g_o >= -ONE));

endmodule

// File: rtl/gauss_pwl_noise.sv
module gauss_pwl_noise
    import gpn_pkg::*;
#(
    parameter logic [31:0] SEED_U = 32'h2545F491,
    parameter logic [31:0] SEED_V = 32'h9E3779B9,
    parameter int          GSEG   = 21,
    parameter int          FRB    = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   en,
    output logic signed [FX_W-1:0] noise_o,
    output logic                   noise_vld_o
);
    localparam int  KB         = 30;
    localparam longint SQRT_HALF = 64'sd759250125;
    localparam int  DEPTH      = 5;

    logic [31:0] u_w, v_w;
    fx_t         f_w, g_w, x_q, xp_q;
    logic signed [63:0] mprod, scaled;
    logic signed [32:0] pair;
    logic [DEPTH-1:0]   fill_q;

    gpn_urng #(.SEED(SEED_U)) u_src (.clk(clk), .rst(rst), .en(en), .rnd_o(u_w));
    gpn_urng #(.SEED(SEED_V)) v_src (.clk(clk), .rst(rst), .en(en), .rnd_o(v_w));

    gpn_feval #(.UW(32), .FRB(FRB)) u_f (
        .clk(clk), .rst(rst), .en(en), .u_i(u_w), .f_o(f_w));
    gpn_geval #(.GSEG(GSEG), .RB(FRB)) u_g (
        .clk(clk), .rst(rst), .en(en), .v_i(v_w), .g_o(g_w));

    always_comb begin
        mprod  = 64'(f_w) * 64'(g_w);
        pair   = 33'(x_q) + 33'(xp_q);
        scaled = 64'(pair) * SQRT_HALF;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fill_q      <= '0;
            x_q         <= '0;
            xp_q        <= '0;
            noise_o     <= '0;
            noise_vld_o <= 1'b0;
        end else begin
            noise_vld_o <= en & fill_q[DEPTH-1];
            if (en) begin
                fill_q  <= {fill_q[DEPTH-2:0], 1'b1};
                x_q     <= fx_t'(mprod >>> FX_FB);
                xp_q    <= x_q;
                noise_o <= fx_t'(scaled >>> KB);
            end
        end
    end

    // R2: a valid sample only follows an enabled edge
    a_r2_vld_needs_en: assert property (@(posedge clk) disable iff (rst) noise_vld_o |-> $past(en));
    // R3: a stalled edge leaves the sample untouched
    a_r3_hold_on_stall: assert property (@(posedge clk) disable iff (rst) !en |=> $stable(noise_o));
    // R3: a stalled edge clears the valid flag
    a_r3_vld_drop: assert property (@(posedge clk) disable iff (rst) !en |=> !noise_vld_o);

endmodule

// File: tb/sim_gauss_pwl_noise.sv
module sim_gauss_pwl_noise;
    localparam time CLK_PERIOD = 10ns;
    localparam logic [31:0] SEED_U = 32'h2545F491;
    localparam logic [31:0] SEED_V = 32'h9E3779B9;
    localparam real TOL = 0.25;
    localparam int  NSTAT = 120000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en  = 1'b0;
    logic signed [31:0] noise_o;
    logic noise_vld_o;

    int checks = 0;
    int errors = 0;
    logic [31:0] su, sv;
    real xa;
    logic signed [31:0] first_val;

    gauss_pwl_noise u0 (.clk(clk), .rst(rst), .en(en), .noise_o(noise_o), .noise_vld_o(noise_vld_o));

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s", req, what);
        end
    endtask

    function automatic logic [31:0] xs(input logic [31:0] s);
        logic [31:0] t;
        t = s ^ (s << 13);
        t = t ^ (t >> 17);
        return t ^ (t << 5);
    endfunction

    function automatic real raw_x(input logic [31:0] a, input logic [31:0] b);
        real u;
        u = (a == 0) ? 0.5 : real'(a);
        u = u / 4294967296.0;
        return $sqrt(-2.0 * $ln(u)) * $cos(6.283185307179586 * real'(b) / 4294967296.0);
    endfunction

    function automatic real yval();
        return real'(noise_o) / 16777216.0;
    endfunction

    task automatic model_reset();
        su = SEED_U;
        sv = SEED_V;
        xa = raw_x(su, sv);
    endtask

    function automatic real model_next();
        real xb, e;
        su = xs(su);
        sv = xs(sv);
        xb = raw_x(su, sv);
        e  = (xa + xb) / $sqrt(2.0);
        xa = xb;
        return e;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        en  = 1'b0;
        repeat (2) @(negedge clk);
        // R1: values while reset is held
        chk(noise_vld_o == 1'b0 && noise_o == 0, "R1",
            $sformatf("vld=%0b noise=%0d, expected 0 and 0", noise_vld_o, noise_o));
        rst = 1'b0;
        model_reset();
    endtask

    task automatic t_fill();
        real e, y;
        do_reset();
        en = 1'b1;
        for (int k = 1; k <= 5; k++) begin
            @(negedge clk);
            // R2: no valid flag during pipeline fill
            chk(noise_vld_o == 1'b0, "R2",
                $sformatf("vld=%0b after enabled edge %0d, expected 0", noise_vld_o, k));
        end
        @(negedge clk);
        chk(noise_vld_o == 1'b1, "R2", $sformatf("vld=%0b after edge 6, expected 1", noise_vld_o));
        first_val = noise_o;
        for (int k = 0; k < 40; k++) begin
            if (k > 0) @(negedge clk);
            e = model_next();
            y = yval();
            // R4 R7 R8: early samples follow the seeded reference formula
            chk(noise_vld_o && (y - e < TOL) && (e - y < TOL), "R8",
                $sformatf("sample %0d = %f vld=%0b, expected %f", k, y, noise_vld_o, e));
        end
    endtask

    task automatic t_gap();
        logic signed [31:0] last;
        real e, y;
        for (int i = 0; i < 60; i++) begin
            last = noise_o;
            en = (i % 3 != 0);
            @(negedge clk);
            if (!en) begin
                // R3: stalled edge holds sample and lowers valid
                chk(noise_vld_o == 1'b0 && noise_o == last, "R3",
                    $sformatf("stall: vld=%0b noise=%0d, expected 0 and %0d", noise_vld_o, noise_o, last));
            end else begin
                e = model_next();
                y = yval();
                // R3: stream resumes exactly where it stopped
                chk(noise_vld_o && (y - e < TOL) && (e - y < TOL), "R3",
                    $sformatf("resume: %f vld=%0b, expected %f", y, noise_vld_o, e));
            end
        end
        en = 1'b1;
    endtask

    task automatic t_repro();
        do_reset();
        en = 1'b1;
        repeat (6) @(negedge clk);
        // R4: the same first sample after every reset
        chk(noise_vld_o && noise_o == first_val, "R4",
            $sformatf("first sample %0d, expected %0d", noise_o, first_val));
        void'(model_next());
    endtask

    task automatic t_stats();
        real s = 0.0, sq = 0.0, y, e, mean, var_, maxabs = 0.0;
        int over4 = 0, pos = 0, bad = 0, novld = 0;
        for (int i = 0; i < NSTAT; i++) begin
            @(negedge clk);
            e = model_next();
            y = yval();
            if (!noise_vld_o) novld++;
            if ((y - e >= TOL) || (e - y >= TOL)) bad++;
            s  += y;
            sq += y * y;
            if (y > 4.0 || y < -4.0) over4++;
            if (y > 0.0) pos++;
            if (y > maxabs) maxabs = y;
            if (-y > maxabs) maxabs = -y;
        end
        mean = s / NSTAT;
        var_ = sq / NSTAT - mean * mean;
        chk(novld == 0, "R2", $sformatf("%0d samples without valid, expected 0", novld));
        chk(bad == 0, "R8", $sformatf("%0d samples off reference, expected 0", bad));
        chk(mean < 0.03 && mean > -0.03, "R9", $sformatf("mean %f, expected within 0.03 of 0", mean));
        chk(var_ > 0.93 && var_ < 1.07, "R9", $sformatf("variance %f, expected 0.93..1.07", var_));
        chk(over4 > 0, "R10", $sformatf("%0d samples beyond 4, expected more than 0", over4));
        chk(maxabs < 9.6, "R5", $sformatf("max magnitude %f, expected below 9.6", maxabs));
        chk(pos > NSTAT * 47 / 100 && pos < NSTAT * 53 / 100, "R6",
            $sformatf("%0d positive of %0d, expected 47%%..53%%", pos, NSTAT));
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_fill();
        t_gap();
        t_repro();
        t_stats();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule